// File: doc/BRIEF.md
# Unum Unpacker

This block turns one self-describing unum, fetched from memory as a single packed word, into the working number format of a variable-precision arithmetic unit. The word puts its size descriptor in the lowest bits, so the block reads that first. The descriptor tells it how wide the exponent and fraction are. The block then pulls out both fields, removes the exponent bias, puts back the hidden bit (or normalizes a subnormal with a leading-zero count) and left-justifies the significand in a wide mantissa made of 64-bit chunks.

The caller pulses `start` with the word on `unumIn` while `busy` is low. Three clock edges later `done` pulses for one cycle. The sign, inexact flag, zero flag, signed exponent, mantissa and chunk count are then valid, and they hold until the next result. The widths of the two size fields are parameters. The defaults allow a 16-bit exponent and a 256-bit fraction.

Top module: `unum_unpack`

## Requirements
- R1: Input layout, lowest bit first: bit 0 sign, bit 1 inexact flag, bits [5:2] exponent width minus one, bits [13:6] fraction width minus one, then the exponent starting at bit 14, then the fraction directly above the exponent. Bits above the fraction are ignored. Sign and inexact flag appear unchanged on `signOut` and `ubitOut`.
- R2: For a nonzero exponent field E of width es, `expOut` equals E − (2^(es−1) − 1), as two's complement.
- R3: For a nonzero exponent, bit 319 of `mantOut` is the hidden one, the fraction follows directly below it with its most significant bit first, and all lower bits are zero. Chunk k is `mantOut[64k+63:64k]`, and chunk 4 is the most significant.
- R4: For a zero exponent with a nonzero fraction, no hidden bit is added. The fraction's leading one is moved to bit 319 and `expOut` = −(2^(es−1) − 1) − z, where z is the number of leading zeros inside the fs-bit fraction.
- R5: For a zero exponent and a zero fraction, `zeroOut` is 1 and `expOut`, `mantOut` and `chunkCount` are 0. Every other value gives `zeroOut` = 0.
- R6: For a nonzero value, `chunkCount` = ceil((fs + 1) / 64).
- R7: A `start` sampled while `busy` is low raises `busy` from the next cycle. `done` is a one-cycle pulse three clock edges after the accepting edge, and `busy` is low while `done` is high.
- R8: A `start` sampled while `busy` is high is ignored. It produces no extra `done`, and the pending result belongs to the accepted word.
- R9: Result outputs change only in the cycle in which `done` is high.
- R10: After reset `busy`, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert `unumIn` |
| unumIn | input | 286 | Packed unum, descriptor in the low bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: results valid |
| signOut | output | 1 | Sign of the value |
| ubitOut | output | 1 | Inexact flag |
| zeroOut | output | 1 | Value is exactly zero |
| expOut | output | 18 | Unbiased signed exponent |
| chunkCount | output | 3 | Significant 64-bit mantissa chunks |
| mantOut | output | 320 | Normalized mantissa, five 64-bit chunks |

## Verification
Every result is due at the third rising edge after the edge that accepts `start`. `busy` is due one edge after acceptance. The bench keeps a cycle counter that copies this timing and compares every output on each falling edge, including the cycles where results must hold steady. Expected exponents and mantissas come from placing the bits one at a time from the decoded field values, so they match R2 to R6 in the cycle the model marks as `done` and in every later cycle until the next result.

// File: rtl/unum_unpack_pkg.sv
package unum_unpack_pkg;

  // Phase strobes from control to datapath
  typedef struct packed {
    logic loadIn;
    logic extract;
    logic normalize;
  } stepStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EXTRACT = 2'd1,
    ST_NORM    = 2'd2
  } ctrlState_e;

endpackage

// File: rtl/unum_unpack_ctrl.sv
module unum_unpack_ctrl
  import unum_unpack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output stepStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  ctrlState_e state;
  logic       doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= (state == ST_NORM);
      case (state)
        ST_IDLE:    if (start) state <= ST_EXTRACT;
        ST_EXTRACT: state <= ST_NORM;
        ST_NORM:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadIn    = (state == ST_IDLE) && start;
    strobes.extract   = (state == ST_EXTRACT);
    strobes.normalize = (state == ST_NORM);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |-> ##3 done);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/unum_unpack_dp.sv
module unum_unpack_dp
  import unum_unpack_pkg::*;
#(
  parameter int ESS     = 4,
  parameter int FSS     = 8,
  parameter int CHUNK_W = 64,
  localparam int ES_MAX = 1 << ESS,
  localparam int FS_MAX = 1 << FSS,
  localparam int DESC_W = 2 + ESS + FSS,
  localparam int PAY_W  = ES_MAX + FS_MAX,
  localparam int IN_W   = DESC_W + PAY_W,
  localparam int CHUNKS = (FS_MAX + CHUNK_W) / CHUNK_W,
  localparam int MANT_W = CHUNKS * CHUNK_W,
  localparam int EXP_W  = ES_MAX + 2,
  localparam int CNT_W  = $clog2(CHUNKS + 1),
  localparam int LZ_W   = FSS + 1
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  stepStrobes_t            strobes,
  input  logic [IN_W-1:0]         unumIn,
  output logic                    signOut,
  output logic                    ubitOut,
  output logic                    zeroOut,
  output logic signed [EXP_W-1:0] expOut,
  output logic [CNT_W-1:0]        chunkCount,
  output logic [MANT_W-1:0]       mantOut
);

  // Phase 1: captured word
  logic [IN_W-1:0]   inReg;
  // Phase 2: decoded fields
  logic              signQ, ubitQ;
  logic [ESS-1:0]    esm1Q;
  logic [FSS-1:0]    fsm1Q;
  logic [ES_MAX-1:0] expRawQ;
  logic [FS_MAX-1:0] fracLQ;
  // Phase 3: results
  logic              zeroQ;
  logic [EXP_W-1:0]  expQ;
  logic [CNT_W-1:0]  chunkQ;
  logic [MANT_W-1:0] mantQ;

  // ---- field extraction ----
  logic [PAY_W-1:0]  payload;
  logic [ESS:0]      esVal;
  logic [FSS:0]      fsVal, padShift;
  logic [ES_MAX-1:0] expMask, expField;
  logic [FS_MAX-1:0] fracMask, fracField, fracLeft;

  always_comb begin
    payload   = inReg[IN_W-1:DESC_W];
    esVal     = {1'b0, inReg[2 +: ESS]} + 1'b1;
    fsVal     = {1'b0, inReg[2+ESS +: FSS]} + 1'b1;
    expMask   = ~({ES_MAX{1'b1}} << esVal);
    fracMask  = ~({FS_MAX{1'b1}} << fsVal);
    expField  = ES_MAX'(payload) & expMask;
    fracField = FS_MAX'(payload >> esVal) & fracMask;
    padShift  = LZ_W'(FS_MAX) - fsVal;
    fracLeft  = fracField << padShift;
  end

  // ---- normalization ----
  function automatic int leadZeros(input logic [FS_MAX-1:0] v);
    int n;
    n = FS_MAX;
    for (int i = 0; i < FS_MAX; i++)
      if (v[i]) n = FS_MAX - 1 - i;
    return n;
  endfunction

  logic              isSub, isZero;
  logic [LZ_W-1:0]   lzV;
  logic [LZ_W:0]     subShift;
  logic [EXP_W-1:0]  biasV, expCalc;
  logic [MANT_W-1:0] baseMant, normMant;
  logic [CNT_W-1:0]  chunkCalc;
  int                sigBits;

  always_comb begin
    isSub     = (expRawQ == '0);
    isZero    = isSub && (fracLQ == '0);
    lzV       = LZ_W'(leadZeros(fracLQ));
    subShift  = {1'b0, lzV} + 1'b1;
    biasV     = (EXP_W'(1) << esm1Q) - EXP_W'(1);
    baseMant  = MANT_W'({~isSub, fracLQ}) << (MANT_W - 1 - FS_MAX);
    normMant  = isSub ? (baseMant << subShift) : baseMant;
    expCalc   = isSub ? (EXP_W'(0) - biasV - EXP_W'(lzV))
                      : (EXP_W'(expRawQ) - biasV);
    sigBits   = int'(fsm1Q) + 2;
    chunkCalc = CNT_W'((sigBits + CHUNK_W - 1) / CHUNK_W);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg   <= '0;
      signQ   <= 1'b0;
      ubitQ   <= 1'b0;
      esm1Q   <= '0;
      fsm1Q   <= '0;
      expRawQ <= '0;
      fracLQ  <= '0;
      signOut <= 1'b0;
      ubitOut <= 1'b0;
      zeroQ   <= 1'b0;
      expQ    <= '0;
      chunkQ  <= '0;
      mantQ   <= '0;
    end else begin
      if (strobes.loadIn) inReg <= unumIn;
      if (strobes.extract) begin
        signQ   <= inReg[0];
        ubitQ   <= inReg[1];
        esm1Q   <= inReg[2 +: ESS];
        fsm1Q   <= inReg[2+ESS +: FSS];
        expRawQ <= expField;
        fracLQ  <= fracLeft;
      end
      if (strobes.normalize) begin
        signOut <= signQ;
        ubitOut <= ubitQ;
        zeroQ   <= isZero;
        expQ    <= isZero ? '0 : expCalc;
        chunkQ  <= isZero ? '0 : chunkCalc;
        mantQ   <= isZero ? '0 : normMant;
      end
    end
  end

  assign zeroOut    = zeroQ;
  assign expOut     = expQ;
  assign chunkCount = chunkQ;
  assign mantOut    = mantQ;

  // R3 R4: a nonzero result always has its leading one at the top
  lead_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.normalize |=> (zeroQ || mantQ[MANT_W-1]));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.normalize |=> ($stable(mantQ) && $stable(expQ) && $stable(zeroQ) && $stable(chunkQ)));
  // R5 R6
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.normalize |=> ((zeroQ == (chunkQ == '0)) && (chunkQ <= CNT_W'(CHUNKS))));
  // R5
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroQ |-> (mantQ == '0 && expQ == '0));

endmodule

// File: rtl/unum_unpack.sv
module unum_unpack
  import unum_unpack_pkg::*;
#(
  parameter int ESS     = 4,
  parameter int FSS     = 8,
  parameter int CHUNK_W = 64,
  localparam int ES_MAX = 1 << ESS,
  localparam int FS_MAX = 1 << FSS,
  localparam int IN_W   = 2 + ESS + FSS + ES_MAX + FS_MAX,
  localparam int CHUNKS = (FS_MAX + CHUNK_W) / CHUNK_W,
  localparam int MANT_W = CHUNKS * CHUNK_W,
  localparam int EXP_W  = ES_MAX + 2,
  localparam int CNT_W  = $clog2(CHUNKS + 1)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IN_W-1:0]         unumIn,
  output logic                    busy,
  output logic                    done,
  output logic                    signOut,
  output logic                    ubitOut,
  output logic                    zeroOut,
  output logic signed [EXP_W-1:0] expOut,
  output logic [CNT_W-1:0]        chunkCount,
  output logic [MANT_W-1:0]       mantOut
);

  stepStrobes_t strobes;

  unum_unpack_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  unum_unpack_dp #(
    .ESS     (ESS),
    .FSS     (FSS),
    .CHUNK_W (CHUNK_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .unumIn     (unumIn),
    .signOut    (signOut),
    .ubitOut    (ubitOut),
    .zeroOut    (zeroOut),
    .expOut     (expOut),
    .chunkCount (chunkCount),
    .mantOut    (mantOut)
  );

endmodule

// File: tb/unum_unpack_test.sv
`timescale 1ns/1ps
module unum_unpack_test;

  localparam int ESS    = 4;
  localparam int FSS    = 8;
  localparam int ES_MAX = 1 << ESS;
  localparam int FS_MAX = 1 << FSS;
  localparam int DESC_W = 2 + ESS + FSS;
  localparam int IN_W   = DESC_W + ES_MAX + FS_MAX;
  localparam int MANT_W = 320;
  localparam int EXP_W  = ES_MAX + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rstN, start;
  logic [IN_W-1:0]         unumIn;
  logic                    busy, done, signOut, ubitOut, zeroOut;
  logic signed [EXP_W-1:0] expOut;
  logic [2:0]              chunkCount;
  logic [MANT_W-1:0]       mantOut;

  unum_unpack uut (
    .clk(clk), .rstN(rstN), .start(start), .unumIn(unumIn),
    .busy(busy), .done(done), .signOut(signOut), .ubitOut(ubitOut),
    .zeroOut(zeroOut), .expOut(expOut), .chunkCount(chunkCount),
    .mantOut(mantOut)
  );

  int checks = 0, fails = 0;

  // reference model state
  int                mCnt = 0;
  bit                mDone = 0;
  bit                eSign = 0, eUbit = 0, eZero = 0;
  int                eExp = 0, eCc = 0;
  logic [MANT_W-1:0] eMant = '0;
  bit                pSign, pUbit, pZero;
  int                pExp, pCc;
  logic [MANT_W-1:0] pMant;

  function automatic logic [IN_W-1:0] packWord(bit s, bit u, int esm1, int fsm1,
                                               logic [15:0] e, logic [255:0] f);
    logic [IN_W-1:0] w;
    int es = esm1 + 1, fs = fsm1 + 1;
    w = '1;                       // junk above the fraction (R1)
    w[0] = s;
    w[1] = u;
    for (int i = 0; i < ESS; i++) w[2+i] = esm1[i];
    for (int i = 0; i < FSS; i++) w[2+ESS+i] = fsm1[i];
    for (int i = 0; i < es; i++)  w[DESC_W+i] = e[i];
    for (int i = 0; i < fs; i++)  w[DESC_W+es+i] = f[i];
    return w;
  endfunction

  task automatic predict(bit s, bit u, int esm1, int fsm1,
                         logic [15:0] e, logic [255:0] f);
    int es = esm1 + 1, fs = fsm1 + 1;
    int bias = (1 << esm1) - 1;
    int ev = 0, top = -1;
    bit fz = 1;
    for (int i = 0; i < es; i++) if (e[i]) ev += (1 << i);
    for (int i = 0; i < fs; i++) if (f[i]) begin fz = 0; top = i; end
    pSign = s; pUbit = u; pMant = '0;
    if (ev == 0 && fz) begin
      pZero = 1; pExp = 0; pCc = 0;
    end else begin
      pZero = 0;
      pCc = (fs + 1 + 63) / 64;
      if (ev == 0) begin
        pExp = -bias - (fs - 1 - top);
        for (int k = top; k >= 0; k--) pMant[MANT_W-1-(top-k)] = f[k];
      end else begin
        pExp = ev - bias;
        pMant[MANT_W-1] = 1'b1;
        for (int k = fs - 1; k >= 0; k--) pMant[MANT_W-2-(fs-1-k)] = f[k];
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, string got, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %s expected %s", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(busy == (mCnt != 0), "R7", "busy", $sformatf("%0b", busy), $sformatf("%0b", mCnt != 0));
    check(done == mDone, "R7 R8", "done", $sformatf("%0b", done), $sformatf("%0b", mDone));
    check(signOut == eSign && ubitOut == eUbit, tag, "sign/ubit R1",
          $sformatf("%0b%0b", signOut, ubitOut), $sformatf("%0b%0b", eSign, eUbit));
    check(zeroOut == eZero, tag, "zero R5", $sformatf("%0b", zeroOut), $sformatf("%0b", eZero));
    check(int'(expOut) == eExp, tag, "exp", $sformatf("%0d", int'(expOut)), $sformatf("%0d", eExp));
    check(mantOut == eMant, tag, "mant", $sformatf("%h", mantOut), $sformatf("%h", eMant));
    check(int'(chunkCount) == eCc, tag, "chunks R6", $sformatf("%0d", chunkCount), $sformatf("%0d", eCc));
  endtask

  // one clock: drive at the falling edge, advance the model, compare at the next falling edge
  task automatic step(bit st, bit s, bit u, int esm1, int fsm1,
                      logic [15:0] e, logic [255:0] f, string tag);
    start  = st;
    unumIn = packWord(s, u, esm1, fsm1, e, f);
    if (mCnt == 0 && st) begin
      mCnt = 2; mDone = 0;
      predict(s, u, esm1, fsm1, e, f);
    end else if (mCnt > 0) begin
      mCnt--;
      mDone = (mCnt == 0);
      if (mDone) begin
        eSign = pSign; eUbit = pUbit; eZero = pZero;
        eExp = pExp; eMant = pMant; eCc = pCc;
      end
    end else begin
      mDone = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic runOne(bit s, bit u, int esm1, int fsm1,
                        logic [15:0] e, logic [255:0] f, string tag, int gap);
    step(1, s, u, esm1, fsm1, e, f, tag);
    for (int i = 0; i < 2 + gap; i++) step(0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] rf;
    logic [15:0]  re;
    rstN = 1'b0; start = 1'b0; unumIn = '0;
    repeat (3) @(negedge clk);
    compareAll("R10");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R10");

    // R5 zero
    runOne(0, 1, 3, 7, 16'h0, '0, "R5", 1);
    // R2 smallest exponent width: bias 0
    runOne(1, 0, 0, 0, 16'h1, 256'h1, "R2 R3", 1);
    // R2 R3 R6 widest value, all ones
    runOne(0, 0, 15, 255, 16'hFFFF, '1, "R2 R3 R6", 1);
    // R4 subnormal, small fraction
    runOne(1, 1, 3, 7, 16'h0, 256'h01, "R4", 0);
    // R4 deepest subnormal
    runOne(0, 0, 15, 255, 16'h0, 256'h1, "R4", 0);
    // R6 chunk boundary: 64 and 65 significant bits
    runOne(0, 0, 4, 62, 16'h3, 256'h5, "R6", 0);
    runOne(0, 0, 4, 63, 16'h3, 256'h5, "R6", 0);
    // R1 sign and ubit with a mid-size environment
    runOne(1, 1, 7, 100, 16'hA5, {128'h0, 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321}, "R1 R2 R3", 2);

    // R8 start while busy is ignored
    step(1, 0, 1, 5, 20, 16'h11, 256'h3F0F, "R8");
    step(1, 1, 0, 2, 9,  16'h3,  256'h7,    "R8");
    step(1, 1, 0, 2, 9,  16'h3,  256'h7,    "R8");
    step(0, 0, 0, 0, 0,  '0,     '0,        "R8 R9");
    step(0, 0, 0, 0, 0,  '0,     '0,        "R9");

    // random sweep over every exponent and fraction width
    for (int n = 0; n < 400; n++) begin
      int esm1 = $urandom_range(0, 15);
      int fsm1 = $urandom_range(0, 255);
      int kind = $urandom_range(0, 7);
      for (int w = 0; w < 8; w++) rf[w*32 +: 32] = $urandom;
      re = 16'($urandom);
      if (kind == 0) re = '0;
      if (kind == 1) begin re = '0; rf = 256'h1 << $urandom_range(0, fsm1); end
      if (kind == 2) begin re = '0; rf = '0; end
      if (kind == 3) re = '1;
      runOne(1'($urandom), 1'($urandom), esm1, fsm1, re, rf,
             "R1 R2 R3 R4 R5 R6", $urandom_range(0, 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule